// File: doc/BRIEF.md
# Reset Handshake Sequencer with Timeout

This block orders the steps of a platform reset. When a reset is requested, it first sends a one-cycle warning strobe to the memory controller. That warning lets the memory controller drain its outstanding cycles and place memory in a safe state. The sequencer then waits for the memory controller to acknowledge. On the acknowledge it drives the active-low platform reset and holds it for a fixed number of cycles. After that it returns to idle.

The acknowledge is not mandatory. If none arrives within a parameterized number of clock ticks, the sequencer stops waiting. It then drives platform reset together with a global-reset request and a power-cycle request. Each request carries a type qualifier. A host-type request resets only the host partition. A global-type request, once acknowledged, also raises the global-reset request, which covers the management partition as well. Transport of the messages and the power sequencing itself sit outside this block.

Top module: `rst_handshake_seq`

## Requirements
- R1: During and directly after block reset, warn_o is 0, plat_rst_n_o is 1, glob_rst_o is 0 and pwr_cycle_o is 0.
- R2: A trigger sampled while idle makes warn_o 1 for exactly one cycle, starting the cycle after the sampling edge. plat_rst_n_o stays 1 during that cycle.
- R3: An acknowledge sampled within TIMEOUT_TICKS cycles after the warning cycle drives plat_rst_n_o to 0 from the next cycle on. It stays 0 for exactly HOLD_CYCLES cycles and then returns to 1.
- R4: The type qualifier trig_global_i is captured with the trigger, where 1 means global and 0 means host. After an acknowledged host request, glob_rst_o and pwr_cycle_o stay 0 throughout the hold. After an acknowledged global request, glob_rst_o is 1 and pwr_cycle_o is 0 throughout the hold.
- R5: If no acknowledge is sampled in the TIMEOUT_TICKS cycles after the warning cycle, plat_rst_n_o, glob_rst_o and pwr_cycle_o all assert in the next cycle. plat_rst_n_o is 0 and the other two are 1. They hold for HOLD_CYCLES cycles, whatever type was requested.
- R6: An acknowledge while idle has no effect: plat_rst_n_o stays 1 and warn_o stays 0.
- R7: An acknowledge during the hold, including after a timeout, does not change the hold length or the glob_rst_o and pwr_cycle_o values.
- R8: Triggers during a sequence are ignored. They cause no second warning and no change of type.
- R9: While plat_rst_n_o is 0, warn_o is 0. glob_rst_o and pwr_cycle_o are 1 only while plat_rst_n_o is 0.
- R10: An acknowledge sampled during the warning cycle itself is ignored. The sequencer still waits for a later acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| trig_i | input | 1 | Reset request |
| trig_global_i | input | 1 | Request type: 1 global, 0 host |
| ack_i | input | 1 | Memory controller acknowledge |
| warn_o | output | 1 | One-cycle warning strobe to the memory controller |
| plat_rst_n_o | output | 1 | Active-low platform reset |
| glob_rst_o | output | 1 | Global reset request |
| pwr_cycle_o | output | 1 | Power-cycle request |

## Verification
Every output comes straight from state registers.

- The warning appears one cycle after the trigger edge.
- Platform reset falls one cycle after the edge that samples the acknowledge, or one cycle after the TIMEOUT_TICKS-th waiting cycle when no acknowledge comes.
- Platform reset rises exactly HOLD_CYCLES cycles after it fell.

The bench drives inputs on the falling clock edge and samples outputs on the next falling edge. It steps one cycle at a time through each sequence and compares every output in every cycle with the value its own model expects for that position. That model covers the acknowledge position, the request type and the injected noise.

// File: rtl/rst_handshake_seq.sv
module rst_handshake_seq #(
  parameter int unsigned TIMEOUT_TICKS = 400_000_000,
  parameter int unsigned HOLD_CYCLES   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic trig_global_i,
  input  logic ack_i,
  output logic warn_o,
  output logic plat_rst_n_o,
  output logic glob_rst_o,
  output logic pwr_cycle_o
);

  localparam int unsigned MAXC = (TIMEOUT_TICKS > HOLD_CYCLES) ? TIMEOUT_TICKS : HOLD_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] TO_LAST   = CW'(TIMEOUT_TICKS - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_WARN, S_WAIT, S_HOLD} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          kind_glob;
  logic          kind_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      kind_glob <= 1'b0;
      kind_pc   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (trig_i) begin
          state     <= S_WARN;
          kind_glob <= trig_global_i;
          kind_pc   <= 1'b0;
        end
        S_WARN: begin
          state <= S_WAIT;
          cnt   <= '0;
        end
        S_WAIT: begin
          if (ack_i) begin
            state <= S_HOLD;
            cnt   <= '0;
          end else if (cnt == TO_LAST) begin
            state     <= S_HOLD;
            cnt       <= '0;
            kind_glob <= 1'b1;
            kind_pc   <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (cnt == HOLD_LAST) begin
            state     <= S_IDLE;
            cnt       <= '0;
            kind_glob <= 1'b0;
            kind_pc   <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign warn_o       = (state == S_WARN);
  assign plat_rst_n_o = (state != S_HOLD);
  assign glob_rst_o   = (state == S_HOLD) && kind_glob;
  assign pwr_cycle_o  = (state == S_HOLD) && kind_pc;

endmodule

// File: rtl/rst_handshake_seq_chk.sv
module rst_handshake_seq_chk #(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input logic clk,
  input logic rst_n,
  input logic trig_i,
  input logic warn_o,
  input logic plat_rst_n_o,
  input logic glob_rst_o,
  input logic pwr_cycle_o
);

  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= 0;
    else if (!plat_rst_n_o) low_run <= low_run + 1;
    else low_run <= 0;
  end

  always_comb begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (plat_rst_n_o && !warn_o && !glob_rst_o && !pwr_cycle_o);
    end
  end

  p_warn_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    warn_o |=> !warn_o);

  p_warn_after_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_o) |-> $past(trig_i));

  p_hold_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    low_run < HOLD_CYCLES + 1);

  p_hold_flags_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!plat_rst_n_o && $past(!plat_rst_n_o)) |-> ($stable(glob_rst_o) && $stable(pwr_cycle_o)));

  p_pwr_with_glob_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle_o |-> glob_rst_o);

  p_no_warn_in_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !plat_rst_n_o |-> !warn_o);

  p_req_only_in_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_rst_o || pwr_cycle_o) |-> !plat_rst_n_o);

endmodule

bind rst_handshake_seq rst_handshake_seq_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .trig_i       (trig_i),
  .warn_o       (warn_o),
  .plat_rst_n_o (plat_rst_n_o),
  .glob_rst_o   (glob_rst_o),
  .pwr_cycle_o  (pwr_cycle_o)
);

// File: tb/rst_handshake_seq_bench.sv
`timescale 1ns/1ps
module rst_handshake_seq_bench;
  localparam int TO   = 12;
  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_i = 1'b0, trig_global_i = 1'b0, ack_i = 1'b0;
  logic warn_o, plat_rst_n_o, glob_rst_o, pwr_cycle_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_handshake_seq #(.TIMEOUT_TICKS(TO), .HOLD_CYCLES(HOLD)) u_rst_handshake_seq (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .trig_global_i(trig_global_i),
    .ack_i(ack_i), .warn_o(warn_o), .plat_rst_n_o(plat_rst_n_o),
    .glob_rst_o(glob_rst_o), .pwr_cycle_o(pwr_cycle_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit exp_glob(bit glob, bit timed_out);
    return glob || timed_out;
  endfunction

  // ackd: waiting cycle index for ack (>= TO means none); warn_ack: ack during warn cycle
  task automatic run_seq(bit glob, int ackd, bit warn_ack, bit noise);
    bit timed_out;
    bit acked;
    string rq;
    trig_i = 1'b1;
    trig_global_i = glob;
    step();
    trig_i = 1'b0;
    chk("R2", "warn strobe", warn_o, 1);
    chk("R2", "plat during warn", plat_rst_n_o, 1);
    ack_i = warn_ack;
    if (noise) begin trig_i = 1'b1; trig_global_i = ~glob; end
    step();
    ack_i = 1'b0;
    chk("R2", "warn single", warn_o, 0);
    chk(warn_ack ? "R10" : "R3", "plat after warn cycle", plat_rst_n_o, 1);
    timed_out = 1'b0;
    acked = 1'b0;
    for (int i = 0; i < TO; i++) begin
      ack_i = (i == ackd);
      if (noise) begin trig_i = $urandom % 2; trig_global_i = $urandom % 2; end
      step();
      ack_i = 1'b0;
      chk("R8", "no second warn", warn_o, 0);
      if (i == ackd) begin acked = 1'b1; break; end
      if (i == TO - 1) timed_out = 1'b1;
      else chk("R3", "plat while waiting", plat_rst_n_o, 1);
    end
    rq = timed_out ? "R5" : "R4";
    for (int h = 0; h < HOLD; h++) begin
      chk(timed_out ? "R5" : "R3", "plat in hold", plat_rst_n_o, 0);
      chk(rq, "glob in hold", glob_rst_o, exp_glob(glob, timed_out));
      chk(rq, "pwr in hold", pwr_cycle_o, timed_out);
      chk("R9", "warn in hold", warn_o, 0);
      if (h == HOLD - 1) begin trig_i = 1'b0; ack_i = 1'b0; end
      else if (noise) begin ack_i = $urandom % 2; trig_i = $urandom % 2; end
      step();
    end
    trig_i = 1'b0;
    ack_i = 1'b0;
    chk(noise ? "R7" : "R3", "plat released", plat_rst_n_o, 1);
    chk("R9", "glob released", glob_rst_o, 0);
    chk("R9", "pwr released", pwr_cycle_o, 0);
    step();
    chk("R8", "no warn after hold", warn_o, 0);
  endtask

  initial begin
    @(negedge clk);
    chk("R1", "plat in reset", plat_rst_n_o, 1);
    chk("R1", "warn in reset", warn_o, 0);
    step();
    rst_n = 1'b1;
    step();
    chk("R1", "plat after reset", plat_rst_n_o, 1);
    chk("R1", "glob after reset", glob_rst_o, 0);
    chk("R1", "pwr after reset", pwr_cycle_o, 0);

    ack_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R6", "plat with idle ack", plat_rst_n_o, 1);
      chk("R6", "warn with idle ack", warn_o, 0);
    end
    ack_i = 1'b0;
    step();

    run_seq(1'b0, 0, 1'b0, 1'b0);
    run_seq(1'b1, 3, 1'b0, 1'b0);
    run_seq(1'b0, TO - 1, 1'b0, 1'b0);
    run_seq(1'b0, TO + 5, 1'b0, 1'b0);
    run_seq(1'b1, TO + 5, 1'b0, 1'b0);
    run_seq(1'b0, 2, 1'b1, 1'b0);
    run_seq(1'b0, TO + 5, 1'b1, 1'b0);
    run_seq(1'b0, TO + 5, 1'b0, 1'b1);

    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < 40; s++) begin
      run_seq($urandom % 2, $urandom % (TO + 4), ($urandom % 4) == 0, $urandom % 2);
      repeat ($urandom % 3) step();
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule